// File: doc/BRIEF.md
# Seeded PRNG register block

A polling-only random number peripheral on a simple 32-bit register bus. Software writes five 32-bit seed words, then writes the control register with the generator-select bit and the start bit both set. The block folds the seeds into a 32-bit xorshift state. It then produces five successive 32-bit words, one per clock, into five read-only output registers. When the fifth word lands it raises a done flag in the status register. Software polls that flag, reads the words and clears the flag by writing status.

The engine is a two-state machine. `ENG_IDLE` waits for an accepted start. The transition `ENG_IDLE -> ENG_RUN` is taken on a control write that meets the start conditions. `ENG_RUN -> ENG_RUN` holds while fewer than five words have been written. `ENG_RUN -> ENG_IDLE` is taken on the cycle that writes the fifth word, which is the same cycle the done flag is set.

Every bus access is answered by a ready pulse one cycle after `bus_valid`. Read data is registered and appears with that pulse. Byte offsets: control 0x000, status 0x010, seed n at 0x140+4n, output n at 0x160+4n (n = 0..4). The window is 0x200 bytes. Only whole-word accesses are supported.

Top module: `prng_regblock`

## Requirements
- R1: After reset, control reads 0x0000_0000, status reads 0x0000_0001 and all five output words read 0.
- R2: `bus_ready` is high exactly in the cycle after a cycle with `bus_valid` high, and low otherwise. Reads of any offset other than control, status and the five outputs (including the seed offsets) return 0. Writes to such offsets, including the output offsets, change nothing.
- R3: Writing seed offset 0x140+4n marks seed n as written. Status bit 1 reads 1 only once all five seeds have been written since reset, and stays 1 until reset.
- R4: Each seed write that leaves all five seeds marked loads the generator state with the XOR of the five latest seed words. If that XOR is zero, the state loads as 0x0000_0001 instead.
- R5: A control write starts generation only if status bit 1 is 1, written bit 3 (generator select) is 1 and written bit 4 (start) is 1. Otherwise no words change and status bit 5 is not set.
- R6: Control reads back the last written value with bit 4 forced to 0.
- R7: A run writes output n (n = 0..4, at 0x160+4n) with the (n+1)-th successive state. Each step is the xorshift x ^= x<<13; x ^= x>>17; x ^= x<<5. The next run continues from the last state.
- R8: Status bit 2 (busy) is 1 for exactly five cycles per run. Status bit 5 is set on the cycle the fifth word is written. A start issued while busy is ignored.
- R9: A status write sets bits 5, 4 and 3 to the written values. Bit 7 always reads 0, bit 0 always reads 1, and bits 1 and 2 are unaffected by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access acknowledge, one cycle after the request |
| bus_rdata | output | 32 | Registered read data, valid with bus_ready |

## Verification
The assertions assume that each request lasts one cycle, that requests carry word-aligned offsets, and that `rst_n` is held low for at least one edge before any request. The bench drives every access as a single-cycle pulse on the falling edge. It leaves at least one idle cycle between requests and applies reset through a task that holds `rst_n` low for two edges. The stimulus sweeps all 32 subsets of written seeds and all four combinations of the select and start bits. It also covers a seed set whose XOR is zero, a back-to-back start during a run, and writes to the read-only outputs.

// File: rtl/prng_pkg.sv
package prng_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 5;
    localparam int ADDR_W    = 9;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 9'h000;
    localparam logic [ADDR_W-1:0] OFF_STAT = 9'h010;
    localparam logic [ADDR_W-1:0] OFF_SEED = 9'h140;
    localparam logic [ADDR_W-1:0] OFF_OUT  = 9'h160;

    // control bit positions
    localparam int CTRL_SEL = 3;
    localparam int CTRL_GO  = 4;

    // status bit positions
    localparam int ST_ERR    = 7;
    localparam int ST_DONE   = 5;
    localparam int ST_MSG    = 4;
    localparam int ST_PART   = 3;
    localparam int ST_BUSY   = 2;
    localparam int ST_SEEDED = 1;
    localparam int ST_BUF    = 0;

    typedef enum logic [0:0] {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    function automatic logic [WORD_W-1:0] xs_step(input logic [WORD_W-1:0] x);
        logic [WORD_W-1:0] t;
        t = x ^ (x << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

endpackage

// File: rtl/prng_seed_track.sv
module prng_seed_track
    import prng_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = NUM_WORDS,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [W-1:0]     wdata_i,
    output logic             load_o,
    output logic [W-1:0]     load_val_o,
    output logic             all_seeded_o
);

    logic [N-1:0]        mask_q;
    logic [N-1:0]        mask_d;
    logic [N-1:0][W-1:0] seed_q;
    logic [W-1:0]        fold;

    always_comb begin
        mask_d = mask_q;
        if (we_i) mask_d = mask_q | (N'(1) << idx_i);
    end

    // fold uses the word being written in place of its stored copy
    always_comb begin
        fold = '0;
        for (int n = 0; n < N; n++) begin
            if (we_i && idx_i == IDX_W'(n)) fold = fold ^ wdata_i;
            else                            fold = fold ^ seed_q[n];
        end
    end

    assign load_o       = we_i && (&mask_d);
    assign load_val_o   = (fold == '0) ? W'(1) : fold;
    assign all_seeded_o = &mask_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_seed
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              seed_q[g] <= '0;
                else if (we_i && idx_i == IDX_W'(g))     seed_q[g] <= wdata_i;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

endmodule

// File: rtl/prng_engine.sv
module prng_engine
    import prng_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = NUM_WORDS,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                load_i,
    input  logic [W-1:0]        load_val_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [N-1:0][W-1:0] words_o
);

    eng_state_e          st_q, st_d;
    logic [IDX_W-1:0]    cnt_q;
    logic [W-1:0]        state_q;
    logic [W-1:0]        step;
    logic                last;

    assign step = xs_step(state_q);
    assign last = (cnt_q == IDX_W'(N-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ENG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ENG_IDLE: if (start_i) st_d = ENG_RUN;
            ENG_RUN:  if (last)    st_d = ENG_IDLE;
            default:               st_d = ENG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o = (st_q == ENG_RUN);
        done_o = (st_q == ENG_RUN) && last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            state_q <= '0;
            words_o <= '0;
        end else begin
            if (st_q == ENG_RUN) begin
                words_o[cnt_q] <= step;
                cnt_q          <= last ? '0 : cnt_q + 1'b1;
            end
            if (load_i)               state_q <= load_val_i;
            else if (st_q == ENG_RUN) state_q <= step;
        end
    end

endmodule

// File: rtl/prng_regblock.sv
module prng_regblock
    import prng_pkg::*;
#(
    parameter int ADDR_BITS = ADDR_W,
    parameter int W         = WORD_W,
    parameter int N         = NUM_WORDS,
    localparam int IDX_W    = $clog2(N),
    localparam int SPAN     = 4 * N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_BITS-1:0] bus_addr,
    input  logic [W-1:0]         bus_wdata,
    output logic                 bus_ready,
    output logic [W-1:0]         bus_rdata
);

    logic                 wr, rd;
    logic                 hit_ctrl, hit_stat, hit_seed, hit_out;
    logic [ADDR_BITS-1:0] seed_off, out_off;
    logic [IDX_W-1:0]     seed_idx, out_idx;

    logic [W-1:0]         ctrl_q;
    logic [2:0]           flags_q;
    logic [W-1:0]         status_w;
    logic [W-1:0]         rd_mux;

    logic                 seeded, load, busy, gen_done, start;
    logic [W-1:0]         load_val;
    logic [N-1:0][W-1:0]  words;

    assign wr = bus_valid && bus_write;
    assign rd = bus_valid && !bus_write;

    assign seed_off = bus_addr - ADDR_BITS'(OFF_SEED);
    assign out_off  = bus_addr - ADDR_BITS'(OFF_OUT);
    assign seed_idx = seed_off[IDX_W+1:2];
    assign out_idx  = out_off[IDX_W+1:2];

    assign hit_ctrl = (bus_addr == ADDR_BITS'(OFF_CTRL));
    assign hit_stat = (bus_addr == ADDR_BITS'(OFF_STAT));
    assign hit_seed = (seed_off < ADDR_BITS'(SPAN)) && (seed_off[1:0] == 2'b00);
    assign hit_out  = (out_off  < ADDR_BITS'(SPAN)) && (out_off[1:0]  == 2'b00);

    assign start = wr && hit_ctrl && bus_wdata[CTRL_GO] && bus_wdata[CTRL_SEL]
                   && seeded && !busy;

    prng_seed_track #(.W(W), .N(N)) u_seeds (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (wr && hit_seed),
        .idx_i        (seed_idx),
        .wdata_i      (bus_wdata),
        .load_o       (load),
        .load_val_o   (load_val),
        .all_seeded_o (seeded)
    );

    prng_engine #(.W(W), .N(N)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .load_i     (load),
        .load_val_i (load_val),
        .busy_o     (busy),
        .done_o     (gen_done),
        .words_o    (words)
    );

    always_comb begin
        status_w             = '0;
        status_w[ST_BUF]     = 1'b1;
        status_w[ST_SEEDED]  = seeded;
        status_w[ST_BUSY]    = busy;
        status_w[ST_DONE:ST_PART] = flags_q;
        status_w[ST_ERR]     = 1'b0;
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl)      rd_mux = ctrl_q;
        else if (hit_stat) rd_mux = status_w;
        else if (hit_out) begin
            for (int n = 0; n < N; n++)
                if (out_idx == IDX_W'(n)) rd_mux = words[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            flags_q   <= '0;
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_valid;
            if (rd) bus_rdata <= rd_mux;
            if (wr && hit_ctrl) begin
                ctrl_q          <= bus_wdata;
                ctrl_q[CTRL_GO] <= 1'b0;
            end
            if (wr && hit_stat) flags_q <= bus_wdata[ST_DONE:ST_PART];
            if (gen_done)       flags_q[2] <= 1'b1;
        end
    end

endmodule

// File: rtl/prng_regblock_chk.sv
module prng_regblock_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_valid,
    input logic bus_ready,
    input logic busy,
    input logic seeded,
    input logic done_flag
);

    logic [2:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (busy)  busy_cnt <= busy_cnt + 3'(busy_cnt != 3'd7);
        else            busy_cnt <= '0;
    end

    // R2
    ready_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> bus_ready);

    // R2
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !bus_ready);

    // R3
    seeded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seeded) |-> seeded);

    // R5
    start_needs_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(seeded));

    // R8
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt < 3'd5);

    // R8
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

endmodule

bind prng_regblock prng_regblock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .busy      (busy),
    .seeded    (seeded),
    .done_flag (flags_q[2])
);

// File: tb/sim_prng_regblock.sv
module sim_prng_regblock;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    prng_regblock u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] t;
        t = x ^ (x << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; fails++;
                $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
                summary();
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        check("R2 ready with read", {31'b0, bus_ready}, 32'd1);
        @(negedge clk);
        check("R2 ready drops", {31'b0, bus_ready}, 32'd0);
    endtask

    task automatic seed_all(input logic [31:0] s0, s1, s2, s3, s4);
        wr(9'h140, s0); wr(9'h144, s1); wr(9'h148, s2);
        wr(9'h14C, s3); wr(9'h150, s4);
    endtask

    // start a run, wait, compare all five words; state advances
    task automatic run_check(string req, inout logic [31:0] st);
        logic [31:0] v;
        wr(9'h000, 32'h18);
        repeat (8) @(negedge clk);
        for (int n = 0; n < 5; n++) begin
            st = xs(st);
            rd(9'(9'h160 + 4 * n), v);
            check(req, v, st);
        end
        wr(9'h010, 32'h0);
    endtask

    initial begin
        logic [31:0] v, st, fold;
        do_reset();

        // R1 reset values
        rd(9'h000, v); check("R1 control", v, 32'h0);
        rd(9'h010, v); check("R1 status", v, 32'h1);
        for (int n = 0; n < 5; n++) begin
            rd(9'(9'h160 + 4 * n), v); check("R1 output", v, 32'h0);
        end

        // R2 unmapped / read-only offsets
        wr(9'h1FC, 32'hDEADBEEF);
        rd(9'h1FC, v); check("R2 unmapped read", v, 32'h0);
        wr(9'h164, 32'h12345678);
        rd(9'h164, v); check("R2 output not writable", v, 32'h0);
        wr(9'h144, 32'hAAAA5555);
        rd(9'h144, v); check("R2 seed reads zero", v, 32'h0);

        // R3 / R5 sweep over all subsets of written seeds
        for (int m = 0; m < 32; m++) begin
            do_reset();
            for (int n = 0; n < 5; n++)
                if (m[n]) wr(9'(9'h140 + 4 * n), 32'(n + 1) * 32'h01010101);
            rd(9'h010, v);
            check("R3 seeded flag", v, (m == 31) ? 32'h3 : 32'h1);
            wr(9'h000, 32'h18);
            repeat (8) @(negedge clk);
            rd(9'h010, v);
            check("R5 start gated by seeds", v, (m == 31) ? 32'h23 : 32'h1);
        end

        // R5 / R6 select and start bit combinations
        for (int c = 0; c < 4; c++) begin
            do_reset();
            seed_all(32'h1, 32'h2, 32'h4, 32'h8, 32'h10);
            wr(9'h000, {27'b0, c[1], c[0], 3'b101});
            repeat (8) @(negedge clk);
            rd(9'h010, v);
            check("R5 select and start", v, (c == 3) ? 32'h23 : 32'h3);
            rd(9'h000, v);
            check("R6 start bit self clears", v, {27'b0, 1'b0, c[0], 3'b101});
            rd(9'h160, v);
            check("R5 no words without start", v, (c == 3) ? xs(32'h1F) : 32'h0);
        end

        // R4 / R7 main generation with several seed sets, two runs each
        do_reset();
        seed_all(32'h13579BDF, 32'h2468ACE0, 32'hF0F0F0F0, 32'h0000FFFF, 32'h80000001);
        st = 32'h13579BDF ^ 32'h2468ACE0 ^ 32'hF0F0F0F0 ^ 32'h0000FFFF ^ 32'h80000001;
        run_check("R7 words run1 set A", st);
        run_check("R7 words run2 set A", st);

        // R4 reseed replaces state; seed 2 rewritten
        wr(9'h148, 32'h0BADF00D);
        st = 32'h13579BDF ^ 32'h2468ACE0 ^ 32'h0BADF00D ^ 32'h0000FFFF ^ 32'h80000001;
        run_check("R4 reseed set B", st);

        // R4 zero fold substitutes one
        do_reset();
        seed_all(32'h5, 32'h5, 32'h9, 32'h9, 32'h0);
        st = 32'h1;
        run_check("R4 zero fold", st);

        // R8 busy during run, start while busy ignored
        do_reset();
        seed_all(32'hCAFE0001, 32'h0, 32'h0, 32'h0, 32'h0);
        fold = 32'hCAFE0001;
        wr(9'h000, 32'h18);
        rd(9'h010, v);
        check("R8 busy in run", v, 32'h7);
        repeat (6) @(negedge clk);
        rd(9'h010, v);
        check("R8 done after run", v, 32'h23);
        wr(9'h010, 32'h0);
        st = fold;
        for (int n = 0; n < 5; n++) st = xs(st);
        // back-to-back starts: second falls in busy window
        wr(9'h000, 32'h18);
        wr(9'h000, 32'h18);
        repeat (8) @(negedge clk);
        for (int n = 0; n < 5; n++) begin
            st = xs(st);
            rd(9'(9'h160 + 4 * n), v);
            check("R8 second start ignored", v, st);
        end

        // R9 status write masking
        wr(9'h010, 32'hFFFFFFFF);
        rd(9'h010, v); check("R9 status all ones", v, 32'h3B);
        wr(9'h010, 32'h00000010);
        rd(9'h010, v); check("R9 status msg only", v, 32'h13);
        wr(9'h010, 32'h0);
        rd(9'h010, v); check("R9 status cleared", v, 32'h3);

        summary();
    end

endmodule